// File: doc/BRIEF.md
# Vector Halfword Extract Unit

This execution-unit slice joins two 128-bit vector operands into one 256-bit value and pulls out a 2-byte field. The byte position comes from the five least significant bits of a 64-bit scalar operand. The field is zero-extended and placed in the upper 64-bit half of a 128-bit result. The lower half of the result is always cleared. A pipeline issues one operation per clock with a valid strobe, and the result appears one clock later.

The slice also checks a vector-enable status bit. When that bit is clear, the operation produces no result. Instead, the slice raises a vector-unavailable flag for the exception logic further down the pipeline. If the index points at the last byte of the joined value, the second byte lies past the end. That byte reads as zero, and a separate out-of-range flag reports it.

Top module: `vhx_unit`

## Requirements
- R1: The byte index is `idx_src[4:0]`, read as an unsigned number from 0 to 31.
- R2: Bits `idx_src[63:5]` have no effect on any output.
- R3: Byte k of the joined value is numbered from the most significant end. Bytes 0 to 15 are `opnd_a[127:120]` down to `opnd_a[7:0]`, and bytes 16 to 31 are `opnd_b[127:120]` down to `opnd_b[7:0]`. An index of 15 therefore takes one byte from each operand.
- R4: For an accepted operation, `res_data[79:72]` is byte index, `res_data[71:64]` is byte index+1, and `res_data[127:80]` is zero.
- R5: `res_data[63:0]` is zero after every accepted operation.
- R6: An operation is accepted when `in_valid`=1 and `vec_en`=1 at a rising clock edge. `res_valid` is then 1 for exactly the following cycle.
- R7: When `in_valid`=1 and `vec_en`=0, the next cycle has `unavail_o`=1, `res_valid`=0 and `res_data`=0. `unavail_o` and `res_valid` are never 1 together.
- R8: With index 31, the low byte `res_data[71:64]` is zero and `oor_o`=1 in the result cycle. For any other index, `oor_o`=0.
- R9: A cycle with `in_valid`=0 makes `res_valid`, `unavail_o` and `oor_o` 0 in the next cycle, and `res_data` keeps its value.
- R10: While `rst_n`=0, all outputs are 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| vec_en | input | 1 | Vector-enable status bit |
| opnd_a | input | 128 | First vector operand (bytes 0 to 15) |
| opnd_b | input | 128 | Second vector operand (bytes 16 to 31) |
| idx_src | input | 64 | Scalar operand holding the byte index |
| res_data | output | 128 | Registered result |
| res_valid | output | 1 | Result strobe |
| unavail_o | output | 1 | Vector-unavailable exception flag |
| oor_o | output | 1 | Second byte lay past the end of the source |

## Verification
The directed patterns are chosen to separate the two operands and the ordering of bytes:

- Index 0 shows which operand is the more significant one.
- Index 15 shows the correct order across the boundary between the operands.
- Index 16 shows that the second operand starts at its most significant byte.
- Indexes 30 and 31 separate the last valid pair from the pair that runs past the end.
- Two scalar values that share their low five bits but differ above them show that the upper bits are ignored.

Operations with the enable bit cleared, idle cycles and a reset in the middle of the run check the flag and hold behaviour. Random operands and indexes are then compared cycle by cycle against a byte-array model.

// File: rtl/vhx_pkg.sv
package vhx_pkg;
  localparam int unsigned VHX_VEC_W       = 128;
  localparam int unsigned VHX_SCALAR_W    = 64;
  localparam int unsigned VHX_FIELD_BYTES = 2;

  typedef struct packed {
    logic valid;
    logic unavail;
    logic oor;
  } vhx_flags_t;
endpackage

// File: rtl/vhx_byte_sel.sv
module vhx_byte_sel #(
  parameter int unsigned NBYTES = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned OFFSET = 0
) (
  input  logic [NBYTES*8-1:0] src,
  input  logic [IDX_W-1:0]    idx,
  output logic [7:0]          byte_o,
  output logic                oob_o
);
  localparam int unsigned POS_W = IDX_W + 1;

  logic [POS_W-1:0] pos;

  always_comb begin
    pos    = POS_W'(idx) + POS_W'(OFFSET);
    oob_o  = (pos >= POS_W'(NBYTES));
    byte_o = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (pos == POS_W'(k)) byte_o = src[(NBYTES-1-k)*8 +: 8];
    end
  end
endmodule

// File: rtl/vhx_pack.sv
module vhx_pack #(
  parameter int unsigned VEC_W   = 128,
  parameter int unsigned FIELD_W = 16
) (
  input  logic [FIELD_W-1:0] field,
  output logic [VEC_W-1:0]   word
);
  localparam int unsigned DW = VEC_W / 2;

  always_comb begin
    word                    = '0;
    word[DW +: FIELD_W]     = field;
  end
endmodule

// File: rtl/vhx_unit.sv
module vhx_unit #(
  parameter int unsigned VEC_W       = vhx_pkg::VHX_VEC_W,
  parameter int unsigned SCALAR_W    = vhx_pkg::VHX_SCALAR_W,
  parameter int unsigned FIELD_BYTES = vhx_pkg::VHX_FIELD_BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                vec_en,
  input  logic [VEC_W-1:0]    opnd_a,
  input  logic [VEC_W-1:0]    opnd_b,
  input  logic [SCALAR_W-1:0] idx_src,
  output logic [VEC_W-1:0]    res_data,
  output logic                res_valid,
  output logic                unavail_o,
  output logic                oor_o
);
  import vhx_pkg::*;

  localparam int unsigned NBYTES  = 2 * VEC_W / 8;
  localparam int unsigned IDX_W   = $clog2(NBYTES);
  localparam int unsigned FIELD_W = FIELD_BYTES * 8;

  logic [2*VEC_W-1:0]     joined;
  logic [IDX_W-1:0]       idx;
  logic [FIELD_W-1:0]     field;
  logic [FIELD_BYTES-1:0] oob;
  logic [VEC_W-1:0]       packed_w;

  assign joined = {opnd_a, opnd_b};
  assign idx    = idx_src[IDX_W-1:0];

  for (genvar g = 0; g < FIELD_BYTES; g++) begin : g_sel
    vhx_byte_sel #(
      .NBYTES(NBYTES),
      .IDX_W (IDX_W),
      .OFFSET(g)
    ) u_sel (
      .src   (joined),
      .idx   (idx),
      .byte_o(field[(FIELD_BYTES-1-g)*8 +: 8]),
      .oob_o (oob[g])
    );
  end

  vhx_pack #(
    .VEC_W  (VEC_W),
    .FIELD_W(FIELD_W)
  ) u_pack (
    .field(field),
    .word (packed_w)
  );

  // next-state
  logic       accept, fault, data_en;
  logic [VEC_W-1:0] data_d, data_q;
  vhx_flags_t flags_d, flags_q;

  always_comb begin
    accept          = in_valid & vec_en;
    fault           = in_valid & ~vec_en;
    data_en         = in_valid;
    data_d          = accept ? packed_w : '0;
    flags_d.valid   = accept;
    flags_d.unavail = fault;
    flags_d.oor     = accept & (|oob);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      data_q  <= '0;
    end else begin
      flags_q <= flags_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign res_data  = data_q;
  assign res_valid = flags_q.valid;
  assign unavail_o = flags_q.unavail;
  assign oor_o     = flags_q.oor;
endmodule

// File: rtl/vhx_chk.sv
module vhx_chk #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             vec_en,
  input logic [VEC_W-1:0] opnd_a,
  input logic [IDX_W-1:0] idx_lo,
  input logic [VEC_W-1:0] res_data,
  input logic             res_valid,
  input logic             unavail_o,
  input logic             oor_o
);
  localparam int unsigned DW = VEC_W / 2;

  p_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && vec_en |=> res_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid && !unavail_o && !oor_o && $stable(res_data));

  p_unavail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !vec_en |=> unavail_o && !res_valid && (res_data == '0));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && unavail_o));

  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_data[DW-1:0] == '0));

  p_ext_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_data[VEC_W-1:DW+16] == '0));

  p_first_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && vec_en && (idx_lo == '0) |=>
      (res_data[DW+15:DW+8] == $past(opnd_a[VEC_W-1 -: 8])));

  p_oor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && vec_en && (idx_lo == '1) |=> oor_o && (res_data[DW+7:DW] == '0));
endmodule

bind vhx_unit vhx_chk #(
  .VEC_W(VEC_W),
  .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .vec_en   (vec_en),
  .opnd_a   (opnd_a),
  .idx_lo   (idx_src[IDX_W-1:0]),
  .res_data (res_data),
  .res_valid(res_valid),
  .unavail_o(unavail_o),
  .oor_o    (oor_o)
);

// File: tb/sim_vhx_unit.sv
`timescale 1ns/1ps
module sim_vhx_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         vec_en = 1'b0;
  logic [127:0] opnd_a = '0;
  logic [127:0] opnd_b = '0;
  logic [63:0]  idx_src = '0;
  logic [127:0] res_data;
  logic         res_valid, unavail_o, oor_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R9";
  string tag_q = "R10";

  logic [127:0] e_data;
  logic         e_valid, e_unavail, e_oor;

  always #10 clk = ~clk;

  vhx_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_en(vec_en),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .idx_src(idx_src),
    .res_data(res_data), .res_valid(res_valid),
    .unavail_o(unavail_o), .oor_o(oor_o)
  );

  function automatic logic [127:0] ref_result(input logic [127:0] a,
                                              input logic [127:0] b,
                                              input int ix);
    logic [7:0] bytes [0:32];
    logic [127:0] r;
    for (int k = 0; k < 16; k++) begin
      bytes[k]    = a[127-8*k -: 8];
      bytes[k+16] = b[127-8*k -: 8];
    end
    bytes[32] = 8'h00;
    r = '0;
    r[79:72] = bytes[ix];
    r[71:64] = bytes[ix+1];
    return r;
  endfunction

  // behavioural reference, updated at the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_data <= '0; e_valid <= 1'b0; e_unavail <= 1'b0; e_oor <= 1'b0;
      tag_q <= "R10";
    end else begin
      int ix;
      ix = int'(idx_src % 32);
      e_valid   <= in_valid && vec_en;
      e_unavail <= in_valid && !vec_en;
      e_oor     <= in_valid && vec_en && (ix == 31);
      if (in_valid) e_data <= vec_en ? ref_result(opnd_a, opnd_b, ix) : '0;
      tag_q <= in_valid ? cur_tag : "R9";
    end
  end

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag_q, res_data, e_data, "res_data");
      check(tag_q, {127'b0, res_valid}, {127'b0, e_valid}, "res_valid");
      check(tag_q, {127'b0, unavail_o}, {127'b0, e_unavail}, "unavail_o");
      check(tag_q, {127'b0, oor_o}, {127'b0, e_oor}, "oor_o");
    end
  end

  task automatic op(input logic [127:0] a, input logic [127:0] b,
                    input logic [63:0] ix, input logic en, input logic v,
                    input string tag);
    @(posedge clk); #2;
    opnd_a = a; opnd_b = b; idx_src = ix; vec_en = en; in_valid = v;
    cur_tag = tag;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  localparam logic [127:0] PA = 128'h00112233_44556677_8899AABB_CCDDEEFF;
  localparam logic [127:0] PB = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

  initial begin
    #5;
    n_chk++;
    if ({res_data, res_valid, unavail_o, oor_o} !== '0) begin
      n_fail++;
      $display("FAIL R10 outputs during reset actual=%h expected=0",
               {res_data, res_valid, unavail_o, oor_o});
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    op(PA, PB, 64'd0, 1'b1, 1'b1, "R3");
    op(PA, PB, 64'd15, 1'b1, 1'b1, "R3");
    op(PA, PB, 64'd16, 1'b1, 1'b1, "R3");
    op(PA, PB, 64'd5, 1'b1, 1'b1, "R1");
    op(PA, PB, 64'hFFFF_FFFF_FFFF_FFE5, 1'b1, 1'b1, "R2");
    op(PA, PB, 64'h8000_0000_0000_0020, 1'b1, 1'b1, "R2");
    op(PA, PB, 64'd30, 1'b1, 1'b1, "R8");
    op(PA, PB, 64'd31, 1'b1, 1'b1, "R8");
    op(PA, PB, 64'd9, 1'b1, 1'b1, "R5");
    op(PA, PB, 64'd7, 1'b0, 1'b1, "R7");
    op(PA, PB, 64'd31, 1'b0, 1'b1, "R7");
    op(PA, PB, 64'd3, 1'b1, 1'b1, "R6");
    op(PA, PB, 64'd4, 1'b1, 1'b1, "R6");
    op(PB, PA, 64'd12, 1'b1, 1'b0, "R9");
    op(PB, PA, 64'd12, 1'b0, 1'b0, "R9");

    for (int i = 0; i < 200; i++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      op(ra, rb, {$urandom, $urandom}, ($urandom % 8) != 0,
         ($urandom % 4) != 0, "R4");
    end

    op(PA, PB, 64'd20, 1'b1, 1'b1, "R4");
    @(posedge clk); #5;
    rst_n = 1'b0;
    #1;
    n_chk++;
    if ({res_data, res_valid, unavail_o, oor_o} !== '0) begin
      n_fail++;
      $display("FAIL R10 outputs after async reset actual=%h expected=0",
               {res_data, res_valid, unavail_o, oor_o});
    end
    in_valid = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    op(PA, PB, 64'd1, 1'b1, 1'b1, "R6");
    repeat (3) @(posedge clk);
    finish_up();
  end
endmodule